// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Freezable Host Copy

This block is a register-mapped time-of-day counter. It counts hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year, all in BCD. A 100 Hz tick input drives the count. The counters themselves are internal. The host reads and writes a separate visible copy over a simple synchronous register bus with address, write data, write strobe and registered read data.

The visible copy normally follows the internal counters one clock behind. A transfer-enable bit in a command register lets the host freeze that copy. While the copy is frozen, the host can read a consistent set of fields and the internal counters keep counting, so no time is lost. Clearing the freeze makes the copy catch up with the running time at once.

The month register also holds two control bits. One is an active-low run bit for the count. The other is an active-low enable for an external 1024 Hz square-wave output.

Top module: `rtc_shadow_core`

## Requirements
- R1: After reset the registers read as follows: address 0, 1, 2, 4 and 0xA read 0x00; address 6 (day) and 8 (date) read 0x01; address 9 (month) reads 0xC1; address 0xB (command) reads 0x80. The output sqw_en is 0.
- R2: While month bit 7 is 0, each cycle with tick_100hz high raises the hundredths field (address 0) by one in BCD, so 0x09 becomes 0x10. While month bit 7 is 1, ticks change no field.
- R3: When hundredths steps from 0x99 to 0x00, seconds (address 1) advances by one. Seconds 0x59 wraps to 0x00 and carries into minutes (address 2). Minutes 0x59 wraps to 0x00 and carries into hours (address 4).
- R4: With hours bit 6 at 0 (24-hour mode), hours count 0x00 to 0x23. The step from 0x23 to 0x00 advances day (address 6, 1..7 with 7 wrapping to 1) and date (address 8).
- R5: With hours bit 6 at 1 (12-hour mode), bits 4:0 count 12, 01 … 11 in BCD and bit 5 is PM. The step from 11 to 12 toggles bit 5. Only the step from 11 PM to 12 AM advances day and date.
- R6: Date wraps to 0x01 after the last day of the month: 30 days for months 4, 6, 9 and 11; 31 days for the other months except 2; 29 days for month 2 when the BCD year is divisible by four, 28 otherwise. A date wrap advances the month. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R7: Writing 0 to bit 7 of address 0xB freezes every visible time field while the internal count continues. Writing 1 there makes a read issued right after that write return the advanced time.
- R8: A write to a time field loads the masked value into both the visible copy and the internal counter, including while frozen. A read right after the write returns that value, and counting continues from it after unfreezing.
- R9: Bits with no function read 0 whatever is written: bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date, bit 5 of month, and bits 6:0 of the command register.
- R10: sqw_en equals the inverse of month bit 6 and changes at the clock edge that takes the month write.
- R11: bus_rdata presents the register addressed in the previous cycle. Addresses 3, 5, 7 and 0xC to 0xF read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle pulse every 10 ms |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_rdata | output | 8 | Registered read data for the previous address |
| sqw_en | output | 1 | Enable for the 1024 Hz square wave |

## Verification
A wrong carry or wrap in the internal counters shows up in the host copy one clock after the tick that causes it. A read started at the next cycle returns the wrong field. For that reason every rollover case is set up by writing the fields just below their limits and applying a single tick. A freeze that leaks shows up as a visible field that moves between two reads while transfer-enable is 0. A freeze that does not release shows up as stale data in the first read after transfer-enable returns to 1. A write that reaches only one of the two copies shows up after the freeze is released, either as the written value being overwritten or as the value before the write coming back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW     = 8;
  localparam int NFIELD = 8;

  typedef logic [DW-1:0] byte_t;
  typedef logic [NFIELD-1:0][DW-1:0] time_vec_t;

  typedef enum logic [2:0] {
    F_HSEC, F_SEC, F_MIN, F_HOUR, F_DAY, F_DATE, F_MON, F_YEAR
  } field_e;

  // year, month, date, day, hour, min, sec, hsec (MSB first)
  localparam time_vec_t RST_TIME = {8'h00, 8'h01, 8'h01, 8'h01,
                                    8'h00, 8'h00, 8'h00, 8'h00};

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic byte_t bcd_to_bin(byte_t v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic byte_t month_last(byte_t mon, byte_t yr);
    byte_t yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic byte_t field_mask(int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1, 2, 3: return 8'h7F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr
  import rtc_pkg::*;
#(
  parameter byte_t WEEK_LAST = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [NFIELD-1:0] wr_sel,
  input  byte_t             wr_val,
  output time_vec_t         tm
);
  time_vec_t nxt;
  logic      c_sec, c_min, c_hour, c_day, c_mon, c_yr;
  logic      pm;
  byte_t     hr12, hr12_inc, hr24;

  always_comb begin
    nxt      = tm;
    pm       = tm[F_HOUR][5];
    hr12     = {3'b000, tm[F_HOUR][4:0]};
    hr12_inc = bcd_inc(hr12);
    hr24     = {2'b00, tm[F_HOUR][5:0]};
    c_sec    = step && (tm[F_HSEC] == 8'h99);
    c_min    = c_sec && (tm[F_SEC] == 8'h59);
    c_hour   = c_min && (tm[F_MIN] == 8'h59);
    c_day    = 1'b0;
    c_mon    = 1'b0;
    c_yr     = 1'b0;

    if (step)  nxt[F_HSEC] = c_sec  ? 8'h00 : bcd_inc(tm[F_HSEC]);
    if (c_sec) nxt[F_SEC]  = c_min  ? 8'h00 : bcd_inc(tm[F_SEC]);
    if (c_min) nxt[F_MIN]  = c_hour ? 8'h00 : bcd_inc(tm[F_MIN]);

    if (c_hour) begin
      if (tm[F_HOUR][6]) begin
        if (hr12 == 8'h11) begin
          nxt[F_HOUR] = {2'b01, ~pm, 5'h12};
          c_day       = pm;
        end else if (hr12 == 8'h12) begin
          nxt[F_HOUR] = {2'b01, pm, 5'h01};
        end else begin
          nxt[F_HOUR] = {2'b01, pm, hr12_inc[4:0]};
        end
      end else if (hr24 == 8'h23) begin
        nxt[F_HOUR] = 8'h00;
        c_day       = 1'b1;
      end else begin
        nxt[F_HOUR] = bcd_inc(hr24);
      end
    end

    if (c_day) begin
      nxt[F_DAY]  = (tm[F_DAY] == WEEK_LAST) ? 8'h01 : bcd_inc(tm[F_DAY]);
      c_mon       = (tm[F_DATE] == month_last(tm[F_MON], tm[F_YEAR]));
      nxt[F_DATE] = c_mon ? 8'h01 : bcd_inc(tm[F_DATE]);
    end
    if (c_mon) begin
      c_yr       = (tm[F_MON] == 8'h12);
      nxt[F_MON] = c_yr ? 8'h01 : bcd_inc(tm[F_MON]);
    end
    if (c_yr) nxt[F_YEAR] = (tm[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(tm[F_YEAR]);

    for (int i = 0; i < NFIELD; i++) begin
      if (wr_sel[i]) nxt[i] = wr_val & field_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tm <= RST_TIME;
    else     tm <= nxt;
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              copy_en,
  input  logic [NFIELD-1:0] wr_sel,
  input  byte_t             wr_val,
  input  time_vec_t         live,
  output time_vec_t         vis
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vis <= RST_TIME;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (wr_sel[i])    vis[i] <= wr_val & field_mask(i);
        else if (copy_en) vis[i] <= live[i];
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
  import rtc_pkg::*;
#(
  parameter int    ADDR_W    = 4,
  parameter int    CMD_ADDR  = 11,
  parameter byte_t WEEK_LAST = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_100hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  output logic              sqw_en
);
  localparam logic [NFIELD-1:0][ADDR_W-1:0] FADDR = {
    ADDR_W'(10), ADDR_W'(9), ADDR_W'(8), ADDR_W'(6),
    ADDR_W'(4),  ADDR_W'(2), ADDR_W'(1), ADDR_W'(0)};
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_ADDR);

  logic [NFIELD-1:0] fld_hit, wr_sel;
  logic              cmd_hit;
  logic              te_q, osc_off_q, step;
  time_vec_t         live_tm, vis_tm;
  byte_t             rd_nxt;

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    assign fld_hit[g] = (bus_addr == FADDR[g]);
    assign wr_sel[g]  = bus_we & fld_hit[g];
  end
  assign cmd_hit = (bus_addr == A_CMD);
  assign step    = tick_100hz & ~osc_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      te_q      <= 1'b1;
      osc_off_q <= 1'b1;
      sqw_en    <= 1'b0;
    end else if (bus_we) begin
      if (cmd_hit) te_q <= bus_wdata[7];
      if (fld_hit[F_MON]) begin
        osc_off_q <= bus_wdata[7];
        sqw_en    <= ~bus_wdata[6];
      end
    end
  end

  rtc_time_ctr #(.WEEK_LAST(WEEK_LAST)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .wr_sel (wr_sel),
    .wr_val (bus_wdata),
    .tm     (live_tm)
  );

  rtc_shadow u_shd (
    .clk     (clk),
    .rst     (rst),
    .copy_en (te_q),
    .wr_sel  (wr_sel),
    .wr_val  (bus_wdata),
    .live    (live_tm),
    .vis     (vis_tm)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (fld_hit[i]) rd_nxt = vis_tm[i];
    end
    if (fld_hit[F_MON]) rd_nxt = vis_tm[F_MON] | {osc_off_q, ~sqw_en, 6'b0};
    if (cmd_hit)        rd_nxt = {te_q, 7'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_100hz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic [DW-1:0]     bus_rdata,
  input logic              sqw_en,
  input logic              te_q,
  input logic              osc_off_q,
  input logic [NFIELD-1:0] wr_sel,
  input time_vec_t         live_tm,
  input time_vec_t         vis_tm
);
  logic unused_addr;
  assign unused_addr = (bus_addr == ADDR_W'(3)) || (bus_addr == ADDR_W'(5)) ||
                       (bus_addr == ADDR_W'(7)) || (bus_addr >= ADDR_W'(12));

  AST_OSC_HALT: assert property (@(posedge clk) disable iff (rst)
    (osc_off_q && wr_sel == '0) |=> $stable(live_tm)); // R2
  AST_HSEC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (tick_100hz && !osc_off_q && wr_sel == '0) |=> (live_tm[0] != $past(live_tm[0]))); // R2
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!te_q && wr_sel == '0) |=> $stable(vis_tm)); // R7
  AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(1)) |=> (vis_tm[1] == live_tm[1])); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    unused_addr |=> (bus_rdata == 8'h00)); // R11
  AST_SQW_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(sqw_en) |-> $past(bus_we && bus_addr == ADDR_W'(9) && !bus_wdata[6])); // R10
endmodule

bind rtc_shadow_core rtc_shadow_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_100hz (tick_100hz),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .sqw_en     (sqw_en),
  .te_q       (te_q),
  .osc_off_q  (osc_off_q),
  .wr_sel     (wr_sel),
  .live_tm    (live_tm),
  .vis_tm     (vis_tm)
);

// File: tb/rtc_shadow_core_tb.sv
`timescale 1ns/1ps
module rtc_shadow_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_100hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       sqw_en;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rtc_shadow_core u_dut (
    .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .sqw_en(sqw_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a;
    @(negedge clk); chk(tag, bus_rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
  endtask

  task automatic set_eve(input logic [7:0] hr);
    wr(4'h0, 8'h99); wr(4'h1, 8'h59); wr(4'h2, 8'h59); wr(4'h4, hr);
  endtask

  task automatic t_reset;
    chk("R1 sqw_en", {7'b0, sqw_en}, 8'h00);
    rd_chk("R1 hsec", 4'h0, 8'h00); rd_chk("R1 sec", 4'h1, 8'h00);
    rd_chk("R1 min", 4'h2, 8'h00);  rd_chk("R1 hour", 4'h4, 8'h00);
    rd_chk("R1 day", 4'h6, 8'h01);  rd_chk("R1 date", 4'h8, 8'h01);
    rd_chk("R1 month", 4'h9, 8'hC1); rd_chk("R1 year", 4'hA, 8'h00);
    rd_chk("R1 cmd", 4'hB, 8'h80);
  endtask

  task automatic t_osc;
    tick(2);
    rd_chk("R2 halted hsec", 4'h0, 8'h00);
    wr(4'h9, 8'h01);
    chk("R10 sqw on", {7'b0, sqw_en}, 8'h01);
    tick(3);
    rd_chk("R2 running hsec", 4'h0, 8'h03);
    wr(4'h0, 8'h09); tick(1);
    rd_chk("R2 bcd step", 4'h0, 8'h10);
  endtask

  task automatic t_cascade;
    set_eve(8'h05); tick(1);
    rd_chk("R3 hsec wrap", 4'h0, 8'h00); rd_chk("R3 sec wrap", 4'h1, 8'h00);
    rd_chk("R3 min wrap", 4'h2, 8'h00);  rd_chk("R3 hour inc", 4'h4, 8'h06);
  endtask

  task automatic t_24h;
    wr(4'h6, 8'h07); wr(4'h8, 8'h15);
    set_eve(8'h23); tick(1);
    rd_chk("R4 hour wrap", 4'h4, 8'h00); rd_chk("R4 day wrap", 4'h6, 8'h01);
    rd_chk("R4 date inc", 4'h8, 8'h16);
  endtask

  task automatic t_12h;
    wr(4'h8, 8'h10);
    set_eve(8'h51); tick(1);
    rd_chk("R5 11am to 12pm", 4'h4, 8'h72); rd_chk("R5 no date step", 4'h8, 8'h10);
    set_eve(8'h52); tick(1);
    rd_chk("R5 12am to 1am", 4'h4, 8'h41);
    set_eve(8'h71); tick(1);
    rd_chk("R5 11pm to 12am", 4'h4, 8'h52); rd_chk("R5 date step", 4'h8, 8'h11);
  endtask

  task automatic t_date;
    wr(4'h9, 8'h02); wr(4'hA, 8'h01); wr(4'h8, 8'h28);
    set_eve(8'h23); tick(1);
    rd_chk("R6 feb28 plain", 4'h8, 8'h01); rd_chk("R6 to march", 4'h9, 8'h03);
    wr(4'h9, 8'h02); wr(4'hA, 8'h04); wr(4'h8, 8'h28);
    set_eve(8'h23); tick(1);
    rd_chk("R6 leap feb29", 4'h8, 8'h29);
    wr(4'h9, 8'h04); wr(4'h8, 8'h30);
    set_eve(8'h23); tick(1);
    rd_chk("R6 apr30 wrap", 4'h8, 8'h01); rd_chk("R6 to may", 4'h9, 8'h05);
    wr(4'h9, 8'h12); wr(4'hA, 8'h99); wr(4'h8, 8'h31);
    set_eve(8'h23); tick(1);
    rd_chk("R6 dec31 date", 4'h8, 8'h01); rd_chk("R6 dec31 month", 4'h9, 8'h01);
    rd_chk("R6 year wrap", 4'hA, 8'h00);
  endtask

  task automatic t_freeze;
    wr(4'h0, 8'h20);
    wr(4'hB, 8'h00);
    rd_chk("R7 cmd frozen", 4'hB, 8'h00);
    tick(5);
    rd_chk("R7 held hsec", 4'h0, 8'h20);
    wr(4'hB, 8'h80);
    rd_chk("R7 released hsec", 4'h0, 8'h25);
  endtask

  task automatic t_write_frozen;
    wr(4'h1, 8'h10);
    wr(4'hB, 8'h00);
    wr(4'h1, 8'h42);
    rd_chk("R8 frozen write", 4'h1, 8'h42);
    tick(2);
    wr(4'hB, 8'h80);
    rd_chk("R8 kept after release", 4'h1, 8'h42);
  endtask

  task automatic t_mask;
    wr(4'h1, 8'hFF); rd_chk("R9 sec mask", 4'h1, 8'h7F);
    wr(4'h2, 8'hD5); rd_chk("R9 min mask", 4'h2, 8'h55);
    wr(4'h6, 8'hFB); rd_chk("R9 day mask", 4'h6, 8'h03);
    wr(4'h8, 8'hE9); rd_chk("R9 date mask", 4'h8, 8'h29);
    wr(4'h9, 8'h27); rd_chk("R9 month mask", 4'h9, 8'h07);
    wr(4'hB, 8'hFF); rd_chk("R9 cmd mask", 4'hB, 8'h80);
  endtask

  task automatic t_sqw;
    wr(4'h9, 8'h41);
    chk("R10 sqw off", {7'b0, sqw_en}, 8'h00);
    rd_chk("R10 month readback", 4'h9, 8'h41);
    wr(4'h9, 8'h01);
    chk("R10 sqw on again", {7'b0, sqw_en}, 8'h01);
  endtask

  task automatic t_unused;
    wr(4'h0, 8'h33);
    wr(4'h3, 8'h55); wr(4'h5, 8'h66); wr(4'hC, 8'h77);
    rd_chk("R11 addr3", 4'h3, 8'h00); rd_chk("R11 addr7", 4'h7, 8'h00);
    rd_chk("R11 addrC", 4'hC, 8'h00); rd_chk("R11 hsec untouched", 4'h0, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset(); t_osc(); t_cascade(); t_24h(); t_12h(); t_date();
    t_freeze(); t_write_frozen(); t_mask(); t_sqw(); t_unused();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule